// File: doc/BRIEF.md
# Channel Frequency to Divider Loader

This block drives the serial programming link of a dual-modulus PLL synthesizer. It accepts a requested channel frequency in kHz and derives the three divider words for a 5 kHz channel raster. The reference divider is the constant 2560. The program counter N is the integer quotient of the frequency by 320. The swallow counter A is the channel index (frequency / 5) less 64·N. The block then shifts the words out as one 32-bit frame on a clock/data/enable link.

The arithmetic uses one sequential restoring divider by 5, run for 20 cycles. Its quotient is the channel index. N is that index shifted right by six, and A is its low six bits. The divider's remainder tells whether the frequency lies on the raster. An off-raster frequency, or a program value too large for its 10-bit field, raises the error output, and no frame is sent.

A start/busy/done handshake controls the block. The one-cycle done pulse marks the end of each request, so a lock monitor knows when to sample lock status after a new load.

Top module: `chan_div_loader`

## Requirements
- R1: During and after reset, busy_o, done_o, err_o and sclk_o are 0 and sen_o is 1.
- R2: A frame is 32 bits, most significant first: 14-bit reference word fixed at 2560, 10-bit N, 7-bit A, then a final control bit of 1. Each bit is sampled by the loaded part on the rising edge of sclk_o.
- R3: For an accepted frequency f, N = floor(f/320) and A = f/5 − 64·N, so A always lies in 0..63.
- R4: If f is not a multiple of 5, err_o is set and no sclk_o edge or sen_o low period occurs for that request.
- R5: If N would exceed 1023 (f ≥ 327680), err_o is set and nothing is transmitted.
- R6: sen_o stays low for the whole frame and returns high on the last falling edge of sclk_o. sdata_o changes only while sclk_o is low. Each sclk_o level lasts HALF_DIV system cycles. sclk_o is low whenever sen_o is high.
- R7: busy_o rises the cycle after an accepted start_i and falls one cycle after sen_o returns high, or after the error decision. A start_i seen while busy_o is high is ignored.
- R8: done_o is a one-cycle pulse at the end of every request, with busy_o low. err_o is valid from that pulse and holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to load a new frequency |
| freq_khz_i | input | 20 | Requested frequency in kHz, unsigned |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Last request rejected (off-raster or N overflow) |
| sclk_o | output | 1 | Serial clock to the synthesizer |
| sdata_o | output | 1 | Serial data, changes while sclk_o is low |
| sen_o | output | 1 | Active-low frame enable |

## Verification
The hardest case to reach is a second start arriving while a frame is already on the wire. It must neither disturb the bits already being shifted nor queue a frame after them. The stimulus issues a valid request, waits until the frame is well under way, and pulses start with a different frequency. It then checks that the captured word still matches the first request and that no new bits appear for a long quiet window. The edges of the N field are reached by choosing frequencies at 327675 kHz (N = 1023, A = 63) and at 327680 kHz (N = 1024).

// File: rtl/chan_div_pkg.sv
package chan_div_pkg;
  localparam int FREQ_W    = 20;
  localparam int REF_W     = 14;
  localparam int PROG_W    = 10;
  localparam int SWAL_W    = 7;
  localparam int FRAME_W   = REF_W + PROG_W + SWAL_W + 1;
  localparam int STEP_KHZ  = 5;
  localparam int MOD_LOG2  = 6;
  localparam int REF_DIV   = 2560;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_DIV  = 2'd1,
    LD_SEND = 2'd2
  } ld_state_e;

  typedef struct packed {
    logic [REF_W-1:0]  ref_w;
    logic [PROG_W-1:0] prog_w;
    logic [SWAL_W-1:0] swal_w;
    logic              ctl;
  } frame_t;
endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W       = 20,
  parameter int DIVISOR = 5,
  localparam int DW     = $clog2(DIVISOR + 1),
  localparam int CW     = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [W-1:0]  dividend,
  output logic [W-1:0]  quotient,
  output logic [DW-1:0] remainder,
  output logic          done
);
  logic [W-1:0]  quo_q, quo_n;
  logic [DW-1:0] rem_q, rem_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          run_q, run_n, done_q, done_n;
  logic [DW:0]   trial;
  logic          ge;

  assign trial = {rem_q, quo_q[W-1]};
  assign ge    = (trial >= (DW+1)'(DIVISOR));

  always_comb begin
    quo_n  = quo_q;
    rem_n  = rem_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    done_n = 1'b0;
    if (go) begin
      quo_n = dividend;
      rem_n = '0;
      cnt_n = '0;
      run_n = 1'b1;
    end else if (run_q) begin
      rem_n = ge ? DW'(trial - (DW+1)'(DIVISOR)) : trial[DW-1:0];
      quo_n = {quo_q[W-2:0], ge};
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == CW'(W - 1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_n;
      rem_q  <= rem_n;
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      done_q <= done_n;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign done      = done_q;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_W  = 32,
  parameter int HALF_DIV = 2,
  localparam int HC_W    = $clog2(HALF_DIV + 1),
  localparam int BC_W    = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] word,
  output logic               sclk,
  output logic               sdata,
  output logic               sen,
  output logic               fin
);
  logic [FRAME_W-1:0] sreg_q, sreg_n;
  logic [HC_W-1:0]    half_q, half_n;
  logic [BC_W-1:0]    bit_q, bit_n;
  logic               sclk_q, sclk_n, sen_q, sen_n;
  logic               act_q, act_n, fin_q, fin_n;

  always_comb begin
    sreg_n = sreg_q;
    half_n = half_q;
    bit_n  = bit_q;
    sclk_n = sclk_q;
    sen_n  = sen_q;
    act_n  = act_q;
    fin_n  = 1'b0;
    if (load) begin
      sreg_n = word;
      half_n = '0;
      bit_n  = '0;
      sclk_n = 1'b0;
      sen_n  = 1'b0;
      act_n  = 1'b1;
    end else if (act_q) begin
      if (half_q == HC_W'(HALF_DIV - 1)) begin
        half_n = '0;
        if (!sclk_q) begin
          sclk_n = 1'b1;
        end else begin
          sclk_n = 1'b0;
          if (bit_q == BC_W'(FRAME_W - 1)) begin
            sen_n = 1'b1;
            act_n = 1'b0;
            fin_n = 1'b1;
          end else begin
            bit_n  = bit_q + 1'b1;
            sreg_n = {sreg_q[FRAME_W-2:0], 1'b0};
          end
        end
      end else begin
        half_n = half_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      half_q <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
      sen_q  <= 1'b1;
      act_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_n;
      half_q <= half_n;
      bit_q  <= bit_n;
      sclk_q <= sclk_n;
      sen_q  <= sen_n;
      act_q  <= act_n;
      fin_q  <= fin_n;
    end
  end

  assign sclk  = sclk_q;
  assign sdata = sreg_q[FRAME_W-1];
  assign sen   = sen_q;
  assign fin   = fin_q;
endmodule

// File: rtl/chan_div_loader.sv
module chan_div_loader
  import chan_div_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_khz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sen_o
);
  localparam int DIV_RW = $clog2(STEP_KHZ + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ld_state_e          state_q, state_n;
  logic               err_q, err_n, done_q, done_n;
  logic               div_go, div_done, shf_load, shf_fin;
  logic [FREQ_W-1:0]  chan_idx;
  logic [DIV_RW-1:0]  chan_rem;
  logic               prog_fits, on_raster;
  frame_t             frame;

  seq_divider #(.W(FREQ_W), .DIVISOR(STEP_KHZ)) u_div (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .go        (div_go),
    .dividend  (freq_khz_i),
    .quotient  (chan_idx),
    .remainder (chan_rem),
    .done      (div_done)
  );

  assign on_raster = (chan_rem == '0);
  assign prog_fits = (chan_idx[FREQ_W-1:MOD_LOG2+PROG_W] == '0);

  always_comb begin
    frame.ref_w  = REF_W'(REF_DIV);
    frame.prog_w = chan_idx[MOD_LOG2 +: PROG_W];
    frame.swal_w = SWAL_W'(chan_idx[MOD_LOG2-1:0]);
    frame.ctl    = 1'b1;
  end

  frame_shifter #(.FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV)) u_shf (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .load  (shf_load),
    .word  (frame),
    .sclk  (sclk_o),
    .sdata (sdata_o),
    .sen   (sen_o),
    .fin   (shf_fin)
  );

  always_comb begin
    state_n  = state_q;
    err_n    = err_q;
    done_n   = 1'b0;
    div_go   = 1'b0;
    shf_load = 1'b0;
    case (state_q)
      LD_IDLE: if (start_i) begin
        div_go  = 1'b1;
        err_n   = 1'b0;
        state_n = LD_DIV;
      end
      LD_DIV: if (div_done) begin
        if (!on_raster || !prog_fits) begin
          err_n   = 1'b1;
          done_n  = 1'b1;
          state_n = LD_IDLE;
        end else begin
          shf_load = 1'b1;
          state_n  = LD_SEND;
        end
      end
      LD_SEND: if (shf_fin) begin
        done_n  = 1'b1;
        state_n = LD_IDLE;
      end
      default: state_n = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= LD_IDLE;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      err_q   <= err_n;
      done_q  <= done_n;
    end
  end

  assign busy_o = (state_q != LD_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/chan_div_loader_chk.sv
module chan_div_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [19:0] freq_khz_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        sclk_o,
  input logic        sdata_o,
  input logic        sen_o
);
  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sen_o |-> !sclk_o);
  // R7
  frame_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_o |-> busy_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && sen_o));
  // R4
  no_send_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_o |-> !err_o);
endmodule

bind chan_div_loader chan_div_loader_chk chk_i (.*);

// File: tb/chan_div_loader_tb.sv
module chan_div_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [19:0] freq_khz_i = '0;
  logic        busy_o, done_o, err_o, sclk_o, sdata_o, sen_o;

  int tests = 0;
  int fails = 0;
  int nbits = 0;
  logic [31:0] cap = '0;

  always #10 clk = ~clk;

  chan_div_loader #(.HALF_DIV(2)) dut_i (.*);

  always @(posedge sclk_o) if (!sen_o) begin
    cap   = {cap[30:0], sdata_o};
    nbits = nbits + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [19:0] f);
    @(negedge clk);
    freq_khz_i = f;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " done seen"}, {31'd0, done_o}, 32'd1);
    chk({req, " busy low at done"}, {31'd0, busy_o}, 32'd0);
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done_o}, 32'd0);
  endtask

  // R2 R3: good frame
  task automatic t_good(input logic [19:0] f);
    int b0 = nbits;
    int en = f / 320;
    int ea = f / 5 - 64 * en;
    logic [31:0] exp = {14'd2560, en[9:0], ea[6:0], 1'b1};
    pulse_start(f);
    chk("R7 busy after start", {31'd0, busy_o}, 32'd1);
    wait_done("R2");
    chk("R2 bit count", nbits - b0, 32'd32);
    chk("R3 frame word", cap, exp);
    chk("R8 err clear", {31'd0, err_o}, 32'd0);
  endtask

  // R4 R5: rejected request
  task automatic t_bad(input logic [19:0] f, input string req);
    int b0 = nbits;
    pulse_start(f);
    wait_done(req);
    chk({req, " err set"}, {31'd0, err_o}, 32'd1);
    chk({req, " no bits sent"}, nbits - b0, 32'd0);
    chk({req, " sen high"}, {31'd0, sen_o}, 32'd1);
  endtask

  // R7: start during busy ignored
  task automatic t_ignore;
    int b0 = nbits;
    pulse_start(20'd300005);
    repeat (60) @(negedge clk);
    chk("R7 busy mid frame", {31'd0, busy_o}, 32'd1);
    pulse_start(20'd1000);
    wait_done("R7");
    chk("R7 first frame kept", cap, {14'd2560, 10'd937, 7'd33, 1'b1});
    repeat (300) @(negedge clk);
    chk("R7 no second frame", nbits - b0, 32'd32);
    chk("R7 idle after", {31'd0, busy_o}, 32'd0);
  endtask

  // R6: sclk period
  task automatic t_timing;
    int hi = 0;
    pulse_start(20'd320000);
    while (sen_o) @(negedge clk);
    while (!sclk_o) @(negedge clk);
    while (sclk_o) begin
      hi++;
      @(negedge clk);
    end
    chk("R6 sclk high length", hi, 32'd2);
    chk("R6 sen low in frame", {31'd0, sen_o}, 32'd0);
    wait_done("R6");
    chk("R6 sen high after", {31'd0, sen_o}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy reset", {31'd0, busy_o}, 32'd0);
    chk("R1 sen reset", {31'd0, sen_o}, 32'd1);
    chk("R1 sclk reset", {31'd0, sclk_o}, 32'd0);
    chk("R1 done/err reset", {30'd0, done_o, err_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", {29'd0, busy_o, sen_o, err_o}, 32'd2);
    t_good(20'd300005);
    t_good(20'd327675);
    t_good(20'd0);
    t_bad(20'd300003, "R4");
    t_good(20'd320000);
    t_bad(20'd327680, "R5");
    t_bad(20'd470000, "R5");
    t_ignore();
    t_timing();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule